// File: doc/BRIEF.md
# Multi-Mode Serial Receiver With Status Flags

This block receives 8-bit serial frames in one of three modes and keeps the status that software polls or takes an interrupt on. It has a receive-full flag, parity, overrun and framing error flags, and a level interrupt request. Two modes are asynchronous and are timed by a 16x oversampling tick. In the plain mode a parity bit may follow the data. In the multiprocessor mode an address/data select bit follows the data. The third mode shifts in eight bits on the rising edges of an external serial clock.

At the end of each frame the block commits the result in a fixed order. In the first clock it posts any error and writes the data register, unless the frame overruns. In the next clock it raises the receive-full flag. The data register is not valid while any error flag is set. Reading the data register clears the receive-full flag. A separate strobe clears the error flags. The interrupt request follows the enable and the four flags through one register stage.

Top module: `mm_serial_rx`

## Requirements
- R1: With `mode` 0 or 1, a falling edge on `rx_line` counts as a start bit only if the line is still low 8 ticks later. A shorter low pulse produces no frame. Data bits are sampled 16 ticks apart, least significant bit first, and are written to the data register once the stop bit has been sampled.
- R2: With `mode` 0 and `par_en`=1, a parity bit follows D7. `par_odd`=0 requires the XOR of the data and parity bits to be 0, and `par_odd`=1 requires it to be 1. A mismatch sets `par_err`. With `par_en`=0 there is no parity bit and `par_err` is never set.
- R3: With `mode` 1, the bit after D7 is an address/data select bit. It is never checked as parity, and `par_err` is never set.
- R4: With `mode` 0 or 1, a stop bit sampled as 0 sets `frm_err`.
- R5: With `mode[1]`=1 (values 2 and 3), eight bits are shifted in on rising edges of `sclk`, least significant bit first. The frame is committed after the eighth bit. `par_err` and `frm_err` are never set in this mode.
- R6: At a frame commit, the error flags take their new values one clock before `rx_full` rises. They do not change in the clock in which `rx_full` rises.
- R7: If a frame completes while `rx_full` is 1, `ovr_err` is set and `rx_data` keeps its previous value.
- R8: A one-clock `rd_strobe` clears `rx_full`. A one-clock `err_clr` clears all three error flags. Neither strobe changes `rx_data`.
- R9: `rx_irq` equals `rx_int_en` AND the OR of `rx_full`, `par_err`, `ovr_err` and `frm_err`, delayed by one clock. With `rx_int_en`=0 it stays 0.
- R10: After reset, every flag, `rx_irq` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial data in, idle high |
| os_tick | input | 1 | 16x oversampling enable pulse for the asynchronous modes |
| sclk | input | 1 | Serial shift clock for the synchronous mode |
| mode | input | 2 | 0 plain async, 1 multiprocessor async, 2 or 3 synchronous |
| par_en | input | 1 | Parity bit present (mode 0) |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| rx_int_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Data register read, clears `rx_full` |
| err_clr | input | 1 | Clears the error flags |
| rx_data | output | 8 | Received data register |
| rx_full | output | 1 | Receive data full flag |
| par_err | output | 1 | Parity error flag |
| ovr_err | output | 1 | Overrun error flag |
| frm_err | output | 1 | Framing error flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
If the bit counter or the tick counter drifts, the first frame after the fault shows it. The data byte comes out shifted or the framing flag is set wrongly, one bit time after the stop bit. If the commit stages are out of order, the clock in which `rx_full` rises shows error flags still changing. If the overrun decision is wrong, the second of two unread frames shows a replaced data byte or a missing overrun flag within two clocks of its last bit. A wrong interrupt register shows up one clock after any flag or enable change.

// File: rtl/mm_rx_pkg.sv
package mm_rx_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC_PLAIN = 2'd0,
    MODE_ASYNC_MPROC = 2'd1,
    MODE_SYNC        = 2'd2,
    MODE_SYNC_ALT    = 2'd3
  } rx_mode_e;

  typedef enum logic [1:0] {
    AS_IDLE  = 2'd0,
    AS_START = 2'd1,
    AS_SHIFT = 2'd2
  } async_state_e;

  function automatic logic mode_is_sync(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/mm_rx_sync_ff.sv
module mm_rx_sync_ff #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mm_rx_async.sv
module mm_rx_async
  import mm_rx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              tick,
  input  logic              rx,
  input  logic              extra_bit,
  input  logic              chk_par,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int unsigned CNT_W = $clog2(OS_RATE);
  localparam int unsigned BIT_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OS_RATE/2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OS_RATE - 1);
  localparam logic [BIT_W-1:0] LAST_D  = BIT_W'(DATA_W);

  async_state_e      state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] sh;
  logic              pbit;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      state <= AS_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      done  <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        AS_IDLE: begin
          if (tick && !rx) begin
            state <= AS_START;
            cnt   <= '0;
          end
        end
        AS_START: begin
          if (tick) begin
            if (cnt == HALF_M1) begin
              if (!rx) begin
                state <= AS_SHIFT;
                cnt   <= '0;
                bitn  <= '0;
              end else begin
                state <= AS_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        AS_SHIFT: begin
          if (tick) begin
            if (cnt == FULL_M1) begin
              cnt  <= '0;
              bitn <= bitn + 1'b1;
              if (bitn < LAST_D) begin
                sh <= {rx, sh[DATA_W-1:1]};
              end else if (extra_bit && (bitn == LAST_D)) begin
                pbit <= rx;
              end else begin
                done  <= 1'b1;
                data  <= sh;
                ferr  <= !rx;
                perr  <= chk_par && ((^sh ^ pbit) != par_odd);
                state <= AS_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= AS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mm_rx_clocked.sv
module mm_rx_clocked #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              sclk_rise,
  input  logic              rx,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt  <= '0;
      sh   <= '0;
      done <= 1'b0;
      data <= '0;
    end else begin
      done <= 1'b0;
      if (sclk_rise) begin
        sh <= {rx, sh[DATA_W-1:1]};
        if (cnt == LAST) begin
          cnt  <= '0;
          done <= 1'b1;
          data <= {rx, sh[DATA_W-1:1]};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mm_rx_flags.sv
module mm_rx_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] din,
  input  logic              perr,
  input  logic              ferr,
  input  logic              rd,
  input  logic              clr,
  input  logic              int_en,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              pe,
  output logic              oe,
  output logic              fe,
  output logic              irq
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
      pe   <= 1'b0;
      oe   <= 1'b0;
      fe   <= 1'b0;
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      // stage 1: errors and data
      pe   <= (pe & ~clr) | (done & perr);
      oe   <= (oe & ~clr) | (done & full);
      fe   <= (fe & ~clr) | (done & ferr);
      if (done && !full) data <= din;
      pend <= done;
      // stage 2: full flag
      full <= (full & ~rd) | pend;
      irq  <= int_en & (full | pe | oe | fe);
    end
  end
endmodule

// File: rtl/mm_serial_rx.sv
module mm_serial_rx
  import mm_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OS_RATE     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic              sclk,
  input  logic [1:0]        mode,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rx_int_en,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              par_err,
  output logic              ovr_err,
  output logic              frm_err,
  output logic              rx_irq
);
  logic rx_s, sclk_s, sclk_d;
  logic sync_sel;
  logic a_done, a_perr, a_ferr, c_done;
  logic [DATA_W-1:0] a_data, c_data;
  logic f_done, f_perr, f_ferr;
  logic [DATA_W-1:0] f_data;

  mm_rx_sync_ff #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst(rst), .d(rx_line), .q(rx_s));
  mm_rx_sync_ff #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst(rst), .d(sclk), .q(sclk_s));

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign sync_sel = mode_is_sync(mode);

  mm_rx_async #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_async (
    .clk(clk), .rst(rst), .hold(sync_sel), .tick(os_tick), .rx(rx_s),
    .extra_bit((mode == MODE_ASYNC_MPROC) || ((mode == MODE_ASYNC_PLAIN) && par_en)),
    .chk_par((mode == MODE_ASYNC_PLAIN) && par_en),
    .par_odd(par_odd), .done(a_done), .data(a_data),
    .perr(a_perr), .ferr(a_ferr));

  mm_rx_clocked #(.DATA_W(DATA_W)) u_clocked (
    .clk(clk), .rst(rst), .hold(!sync_sel), .sclk_rise(sclk_s && !sclk_d),
    .rx(rx_s), .done(c_done), .data(c_data));

  always_comb begin
    if (sync_sel) begin
      f_done = c_done;
      f_data = c_data;
      f_perr = 1'b0;
      f_ferr = 1'b0;
    end else begin
      f_done = a_done;
      f_data = a_data;
      f_perr = a_perr;
      f_ferr = a_ferr;
    end
  end

  mm_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .done(f_done), .din(f_data), .perr(f_perr),
    .ferr(f_ferr), .rd(rd_strobe), .clr(err_clr), .int_en(rx_int_en),
    .data(rx_data), .full(rx_full), .pe(par_err), .oe(ovr_err),
    .fe(frm_err), .irq(rx_irq));
endmodule

// File: rtl/mm_serial_rx_checker.sv
module mm_serial_rx_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              rx_int_en,
  input logic              err_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              par_err,
  input logic              ovr_err,
  input logic              frm_err,
  input logic              rx_irq
);
  assert_errors_first_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_full) && !$past(err_clr)) |-> $stable({par_err, ovr_err, frm_err}));

  assert_parity_mode_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(par_err) |-> ($past(mode) == 2'd0));

  assert_no_framing_sync_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(frm_err) |-> !$past(mode[1]));

  assert_overrun_keeps_data_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_err) |-> $stable(rx_data));

  assert_irq_high_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_int_en && (rx_full || par_err || ovr_err || frm_err)) |=> rx_irq);

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (rst)
    !(rx_int_en && (rx_full || par_err || ovr_err || frm_err)) |=> !rx_irq);
endmodule

bind mm_serial_rx mm_serial_rx_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rst(rst), .mode(mode), .rx_int_en(rx_int_en), .err_clr(err_clr),
  .rx_data(rx_data), .rx_full(rx_full), .par_err(par_err), .ovr_err(ovr_err),
  .frm_err(frm_err), .rx_irq(rx_irq));

// File: tb/test_mm_serial_rx.sv
`timescale 1ns/1ps
module test_mm_serial_rx;
  localparam int BIT_CLK = 32;  // 16 ticks, one tick every 2 clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b1, os_tick = 1'b0, sclk = 1'b0;
  logic [1:0] mode = 2'd0;
  logic par_en = 1'b0, par_odd = 1'b0, rx_int_en = 1'b0;
  logic rd_strobe = 1'b0, err_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, par_err, ovr_err, frm_err, rx_irq;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) os_tick <= 1'b0;
    else     os_tick <= ~os_tick;
  end

  mm_serial_rx i_mm_serial_rx (
    .clk(clk), .rst(rst), .rx_line(rx_line), .os_tick(os_tick), .sclk(sclk),
    .mode(mode), .par_en(par_en), .par_odd(par_odd), .rx_int_en(rx_int_en),
    .rd_strobe(rd_strobe), .err_clr(err_clr), .rx_data(rx_data),
    .rx_full(rx_full), .par_err(par_err), .ovr_err(ovr_err),
    .frm_err(frm_err), .rx_irq(rx_irq));

  typedef struct {
    logic [7:0] data;
    logic pe, oe, fe;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] m_data = 8'h00;
  logic m_full = 0, m_pe = 0, m_oe = 0, m_fe = 0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_commit(input logic [7:0] d, input logic perr, input logic ferr, input string tag);
    exp_t e;
    m_oe = m_oe | m_full;
    if (!m_full) m_data = d;
    m_pe = m_pe | perr;
    m_fe = m_fe | ferr;
    m_full = 1'b1;
    e.data = m_data; e.pe = m_pe; e.oe = m_oe; e.fe = m_fe; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive_bit(input logic b);
    rx_line = b;
    clocks(BIT_CLK);
  endtask

  task automatic send_async(input logic [7:0] d, input bit has_extra, input logic extra,
                            input logic stop, input logic perr, input logic ferr, input string tag);
    push_commit(d, perr, ferr, tag);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (has_extra) drive_bit(extra);
    drive_bit(stop);
    rx_line = 1'b1;
    clocks(2 * BIT_CLK);
  endtask

  task automatic send_sync(input logic [7:0] d, input string tag);
    push_commit(d, 1'b0, 1'b0, tag);
    for (int i = 0; i < 8; i++) begin
      rx_line = d[i];
      clocks(4);
      sclk = 1'b1;
      clocks(4);
      sclk = 1'b0;
    end
    clocks(10);
  endtask

  task automatic do_read(input string tag);
    rd_strobe = 1'b1;
    clocks(1);
    rd_strobe = 1'b0;
    m_full = 1'b0;
    clocks(2);
    check(rx_full == 1'b0, tag, rx_full, 0);
    check(rx_data == m_data, tag, rx_data, m_data);
  endtask

  task automatic do_clear(input string tag);
    err_clr = 1'b1;
    clocks(1);
    err_clr = 1'b0;
    m_pe = 0; m_oe = 0; m_fe = 0;
    clocks(2);
    check({par_err, ovr_err, frm_err} == 3'b000, tag, {par_err, ovr_err, frm_err}, 0);
    check(rx_data == m_data, tag, rx_data, m_data);
  endtask

  // monitor: pop an expected commit each time the design posts one
  initial begin
    logic p_full, p_pe, p_oe, p_fe;
    exp_t e;
    p_full = 0; p_pe = 0; p_oe = 0; p_fe = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if ((rx_full && !p_full) || (ovr_err && !p_oe)) begin
          if (q.size() == 0) begin
            check(1'b0, "unexpected commit", rx_data, 0);
          end else begin
            e = q.pop_front();
            check(rx_data == e.data, {e.tag, " data"}, rx_data, e.data);
            check({par_err, ovr_err, frm_err} == {e.pe, e.oe, e.fe},
                  {e.tag, " flags"}, {par_err, ovr_err, frm_err}, {e.pe, e.oe, e.fe});
            if (rx_full && !p_full)
              check({p_pe, p_oe, p_fe} == {par_err, ovr_err, frm_err},
                    "R6 errors settled before full", {p_pe, p_oe, p_fe}, {par_err, ovr_err, frm_err});
          end
        end
      end
      p_full = rx_full; p_pe = par_err; p_oe = ovr_err; p_fe = frm_err;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    clocks(4);
    rst = 1'b0;
    clocks(2);
    // R10 reset state
    check({rx_full, par_err, ovr_err, frm_err, rx_irq} == 5'b0, "R10 flags after reset",
          {rx_full, par_err, ovr_err, frm_err, rx_irq}, 0);
    check(rx_data == 8'h00, "R10 data after reset", rx_data, 0);

    // R1 plain async frame, interrupt enabled
    rx_int_en = 1'b1;
    send_async(8'hA5, 0, 1'b0, 1'b1, 0, 0, "R1 mode0 A5");
    check(rx_irq == 1'b1, "R9 irq on full", rx_irq, 1);
    do_read("R8 read clears full");
    clocks(2);
    check(rx_irq == 1'b0, "R9 irq drops after read", rx_irq, 0);

    // R1 short low pulse rejected
    rx_line = 1'b0; clocks(8); rx_line = 1'b1;
    clocks(3 * BIT_CLK);
    check(rx_full == 1'b0, "R1 glitch ignored", rx_full, 0);

    // R2 even parity correct
    par_en = 1'b1;
    send_async(8'h3C, 1, 1'b0, 1'b1, 0, 0, "R2 even parity ok");
    do_read("R8 read after parity ok");

    // R2 odd parity wrong
    par_odd = 1'b1;
    send_async(8'h01, 1, 1'b1, 1'b1, 1, 0, "R2 odd parity error");
    check(rx_irq == 1'b1, "R9 irq on parity error", rx_irq, 1);
    do_read("R8 read after parity error");
    do_clear("R8 clear errors");
    clocks(1);
    check(rx_irq == 1'b0, "R9 irq cleared", rx_irq, 0);
    par_odd = 1'b0;

    // R3 multiprocessor mode: select bit never parity
    mode = 2'd1;
    send_async(8'h80, 1, 1'b1, 1'b1, 0, 0, "R3 mode1 select bit 1");
    do_read("R3 read mode1");
    send_async(8'h80, 1, 1'b0, 1'b1, 0, 0, "R3 mode1 select bit 0");
    do_read("R3 read mode1 b");

    // R4 framing errors
    mode = 2'd0; par_en = 1'b0;
    send_async(8'h5A, 0, 1'b0, 1'b0, 0, 1, "R4 mode0 bad stop");
    do_read("R4 read"); do_clear("R4 clear");
    mode = 2'd1;
    send_async(8'hC3, 1, 1'b0, 1'b0, 0, 1, "R4 mode1 bad stop");
    do_read("R4 read mode1"); do_clear("R4 clear mode1");

    // R7 async overrun
    mode = 2'd0;
    send_async(8'h11, 0, 1'b0, 1'b1, 0, 0, "R7 first frame");
    send_async(8'h22, 0, 1'b0, 1'b1, 0, 0, "R7 overrun frame");
    check(rx_data == 8'h11, "R7 data kept", rx_data, 8'h11);
    do_read("R7 read"); do_clear("R7 clear");

    // R5 synchronous mode
    mode = 2'd2; rx_line = 1'b0;
    clocks(4);
    send_sync(8'hC3, "R5 sync C3");
    check({par_err, frm_err} == 2'b00, "R5 no parity/framing", {par_err, frm_err}, 0);
    do_read("R5 read");
    send_sync(8'h5A, "R5 sync 5A");
    send_sync(8'h99, "R5 R7 sync overrun");
    do_read("R5 read overrun"); do_clear("R5 clear");
    mode = 2'd3;
    send_sync(8'h6E, "R5 mode3 sync");
    do_read("R5 read mode3");

    // R9 interrupt disabled
    mode = 2'd0; rx_line = 1'b1; rx_int_en = 1'b0;
    clocks(2 * BIT_CLK);
    send_async(8'h77, 0, 1'b0, 1'b1, 0, 0, "R9 frame int off");
    check(rx_irq == 1'b0, "R9 irq stays low", rx_irq, 0);
    do_read("R9 read");

    clocks(8);
    check(q.size() == 0, "all expected commits seen", q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule